// File: doc/BRIEF.md
# Reference Loss Monitor with Automatic Switchover

This block supervises up to four asynchronous reference clocks from a single fast monitor clock. Each reference has a watchdog counter in the monitor clock domain. The counter restarts on every synchronized rising edge of its reference. If the counter reaches a programmed terminal count before the next edge arrives, that reference is flagged as lost. A lost reference returns to service only after a programmable number of consecutive on-time periods.

From the healthy references, a selector picks the active one by a 4-bit priority per input. When the active reference fails, the selector moves to the best remaining input. When no input is usable, it raises a holdover request to the downstream loop. Priorities are used as follows:

- The selector can be non-revertive, keeping the current input, or revertive, returning to a recovered input of higher priority.
- A manual mode forces the active input.

Each rising loss flag also sets a sticky status bit. The sticky bits drive an active-low interrupt until software clears them by writing ones.

Set the terminal count to at least one reference period plus two or three monitor cycles, so that a healthy input never times out.

Top module: `refmon_switch`

## Requirements
- R1: After reset, all loss flags read 1, `holdover` is 1, `irq_n` is 1 and `sel_idx` is 0.
- R2: A loss flag is tied to the reference period P, counted in monitor cycles, and to the terminal count T. It is never set when P <= T+1. It is set when P >= T+2, or when the reference stops.
- R3: A lost input clears its flag only after it has had `good_need` consecutive on-time edges. An on-time edge is one that arrives before expiry. The first edge after a loss does not count, and a `good_need` of 0 acts as 1.
- R4: When the selector chooses, it takes the healthy input with the numerically largest priority. Ties go to the lowest input index.
- R5: In automatic mode, if the active input is lost, `sel_idx` moves to the best healthy input on the next cycle. The loss of an inactive input leaves `sel_idx` unchanged.
- R6: With `revertive` at 0, the selection stays on a healthy active input, even when another input of higher priority is healthy.
- R7: With `revertive` at 1, the selection moves to a healthy input whose priority is strictly higher than that of the active input.
- R8: When every input is lost, `holdover` goes to 1 and `sel_idx` keeps its last value. When an input becomes healthy again, `holdover` returns to 0.
- R9: A rising loss flag sets its sticky bit, and any set sticky bit drives `irq_n` to 0. Writing 1 on a `los_clr` bit clears that sticky bit. If a set and a clear arrive in the same cycle, the set wins.
- R10: With `manual_en` at 1, `sel_idx` follows `manual_sel` while that input is healthy. If that input is lost, `holdover` goes to 1 without any automatic switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mon | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | NUM_REF | Asynchronous reference clocks |
| timeout_cfg | input | NUM_REF*CNT_W | Terminal count per input, input i in bits [i*CNT_W +: CNT_W] |
| prio_cfg | input | NUM_REF*PRIO_W | Priority per input, input i in bits [i*PRIO_W +: PRIO_W]; larger value wins |
| good_need | input | GOOD_W | On-time periods required to requalify a lost input |
| revertive | input | 1 | 1 = return to a recovered input of higher priority |
| manual_en | input | 1 | 1 = forced selection |
| manual_sel | input | IDX_W | Input index forced in manual mode |
| los_clr | input | NUM_REF | Write-one-to-clear of the sticky loss bits |
| sel_idx | output | IDX_W | Index of the active reference |
| holdover | output | 1 | Holdover request, no usable reference |
| los | output | NUM_REF | Live loss-of-signal flag per input |
| irq_n | output | 1 | Active-low interrupt, any sticky bit set |

## Verification
The hardest case to reach from the ports is the exact edge of the timeout: periods of T+1 and T+2 monitor cycles must land on opposite sides of the loss decision. The bench generates each reference from its own phase counter in the monitor clock domain, so the periods are exact, and runs input 0 at both values. A second case is the requalification window. The stimulus stops an inactive reference, restarts it, and samples the flag after only three edges, and again after enough edges. This shows that the first edge after a loss is not counted. Revertive return and holdover are reached by stopping and restarting references in sequence while the priorities are set up to include a tie.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
  typedef enum logic {
    SEL_TRACK = 1'b0,
    SEL_HOLD  = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/refmon_sync_edge.sv
module refmon_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 3'b000;
    else        sh_q <= {sh_q[1:0], async_in};
  end

  assign rise_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/refmon_channel.sv
module refmon_channel #(
  parameter int CNT_W  = 16,
  parameter int GOOD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_i,
  input  logic [CNT_W-1:0]  timeout_i,
  input  logic [GOOD_W-1:0] good_need_i,
  output logic              los_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [GOOD_W-1:0] good_q, good_d;
  logic              late_q, late_d;
  logic              los_q, los_d;
  logic [GOOD_W:0]   good_inc, need;

  assign good_inc = {1'b0, good_q} + 1'b1;
  assign need     = (good_need_i == '0) ? {{GOOD_W{1'b0}}, 1'b1}
                                        : {1'b0, good_need_i};

  always_comb begin
    cnt_d  = cnt_q;
    good_d = good_q;
    late_d = late_q;
    los_d  = los_q;
    if (edge_i) begin
      cnt_d  = '0;
      late_d = 1'b0;
      if (late_q) begin
        good_d = '0;
      end else if (los_q) begin
        if (good_inc >= need) begin
          los_d  = 1'b0;
          good_d = '0;
        end else begin
          good_d = good_inc[GOOD_W-1:0];
        end
      end
    end else if (cnt_q == timeout_i) begin
      late_d = 1'b1;
      los_d  = 1'b1;
      good_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      good_q <= '0;
      late_q <= 1'b0;
      los_q  <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      good_q <= good_d;
      late_q <= late_d;
      los_q  <= los_d;
    end
  end

  assign los_o = los_q;
endmodule

// File: rtl/refmon_select.sv
module refmon_select
  import refmon_pkg::*;
#(
  parameter int NUM_REF = 4,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = $clog2(NUM_REF)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REF-1:0]        los_i,
  input  logic [NUM_REF*PRIO_W-1:0] prio_i,
  input  logic                      revertive_i,
  input  logic                      manual_en_i,
  input  logic [IDX_W-1:0]          manual_sel_i,
  output logic [IDX_W-1:0]          sel_o,
  output logic                      hold_o
);
  logic [IDX_W-1:0]  cur_q, cur_d, best;
  sel_mode_e         mode_q, mode_d;
  logic [PRIO_W-1:0] best_p, cur_p;
  logic              found;

  always_comb begin
    best   = '0;
    best_p = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_REF; i++) begin
      if (!los_i[i] && (!found || prio_i[i*PRIO_W +: PRIO_W] > best_p)) begin
        best   = i[IDX_W-1:0];
        best_p = prio_i[i*PRIO_W +: PRIO_W];
        found  = 1'b1;
      end
    end
  end

  assign cur_p = prio_i[cur_q*PRIO_W +: PRIO_W];

  always_comb begin
    cur_d  = cur_q;
    mode_d = mode_q;
    if (manual_en_i) begin
      if (!los_i[manual_sel_i]) begin
        cur_d  = manual_sel_i;
        mode_d = SEL_TRACK;
      end else begin
        mode_d = SEL_HOLD;
      end
    end else if (found) begin
      if (mode_q == SEL_HOLD || los_i[cur_q]) begin
        cur_d  = best;
        mode_d = SEL_TRACK;
      end else if (revertive_i && best_p > cur_p) begin
        cur_d = best;
      end
    end else begin
      mode_d = SEL_HOLD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      mode_q <= SEL_HOLD;
    end else begin
      cur_q  <= cur_d;
      mode_q <= mode_d;
    end
  end

  assign sel_o  = cur_q;
  assign hold_o = (mode_q == SEL_HOLD);
endmodule

// File: rtl/refmon_switch.sv
module refmon_switch #(
  parameter int NUM_REF = 4,
  parameter int CNT_W   = 16,
  parameter int PRIO_W  = 4,
  parameter int GOOD_W  = 4,
  localparam int IDX_W  = $clog2(NUM_REF)
) (
  input  logic                      clk_mon,
  input  logic                      rst_n,
  input  logic [NUM_REF-1:0]        ref_in,
  input  logic [NUM_REF*CNT_W-1:0]  timeout_cfg,
  input  logic [NUM_REF*PRIO_W-1:0] prio_cfg,
  input  logic [GOOD_W-1:0]         good_need,
  input  logic                      revertive,
  input  logic                      manual_en,
  input  logic [IDX_W-1:0]          manual_sel,
  input  logic [NUM_REF-1:0]        los_clr,
  output logic [IDX_W-1:0]          sel_idx,
  output logic                      holdover,
  output logic [NUM_REF-1:0]        los,
  output logic                      irq_n
);
  logic [1:0]         rst_sh_q;
  logic               rst_l;
  logic [NUM_REF-1:0] rise, los_w, los_q, sticky_q, sticky_d;

  always_ff @(posedge clk_mon or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_l = rst_sh_q[1];

  for (genvar g = 0; g < NUM_REF; g++) begin : g_ch
    refmon_sync_edge u_sync (
      .clk      (clk_mon),
      .rst_n    (rst_l),
      .async_in (ref_in[g]),
      .rise_o   (rise[g])
    );
    refmon_channel #(.CNT_W(CNT_W), .GOOD_W(GOOD_W)) u_chan (
      .clk         (clk_mon),
      .rst_n       (rst_l),
      .edge_i      (rise[g]),
      .timeout_i   (timeout_cfg[g*CNT_W +: CNT_W]),
      .good_need_i (good_need),
      .los_o       (los_w[g])
    );
  end

  refmon_select #(.NUM_REF(NUM_REF), .PRIO_W(PRIO_W)) u_sel (
    .clk          (clk_mon),
    .rst_n        (rst_l),
    .los_i        (los_w),
    .prio_i       (prio_cfg),
    .revertive_i  (revertive),
    .manual_en_i  (manual_en),
    .manual_sel_i (manual_sel),
    .sel_o        (sel_idx),
    .hold_o       (holdover)
  );

  assign sticky_d = (sticky_q & ~los_clr) | (los_w & ~los_q);

  always_ff @(posedge clk_mon or negedge rst_l) begin
    if (!rst_l) begin
      los_q    <= '1;
      sticky_q <= '0;
    end else begin
      los_q    <= los_w;
      sticky_q <= sticky_d;
    end
  end

  assign los   = los_w;
  assign irq_n = ~|sticky_q;
endmodule

// File: rtl/refmon_switch_chk.sv
module refmon_switch_chk #(
  parameter int NUM_REF = 4,
  localparam int IDX_W  = $clog2(NUM_REF)
) (
  input logic               clk_mon,
  input logic               rst_n,
  input logic [NUM_REF-1:0] los,
  input logic [IDX_W-1:0]   sel_idx,
  input logic               holdover,
  input logic               irq_n,
  input logic               revertive,
  input logic               manual_en
);
  logic [NUM_REF-1:0] los_s;

  always_ff @(posedge clk_mon) los_s <= los;

  assert_all_lost_hold_R8: assert property (@(posedge clk_mon) disable iff (!rst_n)
    (&los) |=> holdover);

  assert_hold_keeps_sel_R8: assert property (@(posedge clk_mon) disable iff (!rst_n)
    (holdover && (&los) && !manual_en) |=> $stable(sel_idx));

  assert_auto_healthy_R5: assert property (@(posedge clk_mon) disable iff (!rst_n)
    (!manual_en && !(&los)) |=> (!holdover && !los_s[sel_idx]));

  assert_nonrev_keep_R6: assert property (@(posedge clk_mon) disable iff (!rst_n)
    (!revertive && !manual_en && !holdover && !los[sel_idx]) |=> $stable(sel_idx));

  assert_sticky_irq_R9: assert property (@(posedge clk_mon) disable iff (!rst_n)
    ((los & ~los_s) != '0) |=> !irq_n);
endmodule

bind refmon_switch refmon_switch_chk #(.NUM_REF(NUM_REF)) u_chk (
  .clk_mon   (clk_mon),
  .rst_n     (rst_n),
  .los       (los),
  .sel_idx   (sel_idx),
  .holdover  (holdover),
  .irq_n     (irq_n),
  .revertive (revertive),
  .manual_en (manual_en)
);

// File: tb/refmon_switch_bench.sv
module refmon_switch_bench;
  localparam int N = 4, CW = 16, PW = 4, GW = 4, IW = 2;

  logic          clk_mon = 1'b0;
  logic          rst_n;
  logic [N-1:0]  ref_in;
  logic [N*CW-1:0] timeout_cfg;
  logic [N*PW-1:0] prio_cfg;
  logic [GW-1:0] good_need;
  logic          revertive, manual_en;
  logic [IW-1:0] manual_sel;
  logic [N-1:0]  los_clr;
  logic [IW-1:0] sel_idx;
  logic          holdover, irq_n;
  logic [N-1:0]  los;

  int checks = 0, errors = 0;
  bit done = 0;
  int per [N];
  int ph  [N];
  bit run [N];

  refmon_switch u_refmon_switch (
    .clk_mon(clk_mon), .rst_n(rst_n), .ref_in(ref_in), .timeout_cfg(timeout_cfg),
    .prio_cfg(prio_cfg), .good_need(good_need), .revertive(revertive),
    .manual_en(manual_en), .manual_sel(manual_sel), .los_clr(los_clr),
    .sel_idx(sel_idx), .holdover(holdover), .los(los), .irq_n(irq_n)
  );

  always #10 clk_mon = ~clk_mon;

  initial begin
    ref_in = '0;
    for (int i = 0; i < N; i++) begin per[i] = 8; ph[i] = 0; run[i] = 0; end
    forever begin
      @(negedge clk_mon);
      for (int i = 0; i < N; i++) begin
        if (run[i]) begin
          ref_in[i] = (ph[i] < per[i] / 2);
          ph[i] = (ph[i] + 1 >= per[i]) ? 0 : ph[i] + 1;
        end else begin
          ref_in[i] = 1'b0;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk_mon);
  endtask

  task automatic set_run(input int i, input bit on);
    @(posedge clk_mon);
    run[i] = on;
    ph[i] = 0;
  endtask

  task automatic clear_sticky(input logic [N-1:0] m);
    @(negedge clk_mon); los_clr = m;
    @(negedge clk_mon); los_clr = '0;
    wait_neg(3);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    wait_neg(3);
    chk("R1 los", los, 4'hF);
    chk("R1 holdover", holdover, 1);
    chk("R1 irq_n", irq_n, 1);
    chk("R1 sel_idx", sel_idx, 0);
    rst_n = 1'b1;
    wait_neg(4);
    chk("R1 los after release", los, 4'hF);
  endtask

  task automatic t_qualify;
    for (int i = 0; i < N; i++) begin run[i] = 1; ph[i] = 0; end
    wait_neg(80);
    chk("R3 all qualified", los, 0);
    chk("R8 holdover left", holdover, 0);
    chk("R4 highest priority", sel_idx, 1);
    chk("R9 no loss no irq", irq_n, 1);
  endtask

  task automatic t_boundary;
    @(posedge clk_mon); per[0] = 13;
    wait_neg(100);
    chk("R2 period T+1 healthy", los[0], 0);
    chk("R2 period T+1 never lost", irq_n, 1);
    @(posedge clk_mon); per[0] = 14;
    wait_neg(100);
    chk("R2 period T+2 lost", los[0], 1);
    chk("R5 inactive loss keeps sel", sel_idx, 1);
    chk("R9 irq on loss", irq_n, 0);
    @(posedge clk_mon); per[0] = 8;
    wait_neg(100);
    chk("R2 back to healthy", los[0], 0);
    clear_sticky(4'h1);
    chk("R9 clear irq", irq_n, 1);
  endtask

  task automatic t_recovery;
    set_run(2, 0);
    wait_neg(30);
    chk("R2 stopped lost", los[2], 1);
    chk("R9 sticky irq", irq_n, 0);
    @(negedge clk_mon); los_clr = 4'h4;
    @(negedge clk_mon); los_clr = 4'h0;
    wait_neg(2);
    chk("R9 irq after clear", irq_n, 0 + 1);
    set_run(2, 1);
    wait_neg(20);
    chk("R3 not yet requalified", los[2], 1);
    wait_neg(40);
    chk("R3 requalified", los[2], 0);
    chk("R9 recovery no irq", irq_n, 1);
  endtask

  task automatic t_failover;
    set_run(1, 0);
    wait_neg(30);
    chk("R5 active lost flag", los[1], 1);
    chk("R5 switched, tie to lower index", sel_idx, 2);
    chk("R5 no holdover", holdover, 0);
    set_run(1, 1);
    wait_neg(80);
    chk("R3 ref1 back", los[1], 0);
    chk("R6 nonrevertive stays", sel_idx, 2);
  endtask

  task automatic t_revert;
    @(negedge clk_mon); revertive = 1'b1;
    wait_neg(4);
    chk("R7 revert to higher", sel_idx, 1);
    @(negedge clk_mon); revertive = 1'b0;
    clear_sticky(4'hF);
  endtask

  task automatic t_holdover;
    @(posedge clk_mon);
    for (int i = 0; i < N; i++) run[i] = 0;
    wait_neg(40);
    chk("R8 all lost", los, 4'hF);
    chk("R8 holdover", holdover, 1);
    chk("R8 sel kept", sel_idx, 1);
    chk("R9 irq", irq_n, 0);
    @(posedge clk_mon);
    for (int i = 0; i < N; i++) begin run[i] = 1; ph[i] = 0; end
    wait_neg(80);
    chk("R8 holdover exit", holdover, 0);
    chk("R4 reselect best", sel_idx, 1);
    clear_sticky(4'hF);
  endtask

  task automatic t_manual;
    @(negedge clk_mon); manual_sel = 2'd3; manual_en = 1'b1;
    wait_neg(4);
    chk("R10 manual pick", sel_idx, 3);
    chk("R10 manual no hold", holdover, 0);
    set_run(3, 0);
    wait_neg(30);
    chk("R10 manual lost holds", holdover, 1);
    chk("R10 no auto switch", sel_idx, 3);
    @(negedge clk_mon); manual_en = 1'b0;
    wait_neg(4);
    chk("R5 auto after manual", sel_idx, 1);
    chk("R5 holdover cleared", holdover, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    timeout_cfg = {N{16'd12}};
    prio_cfg = {4'd5, 4'd5, 4'd6, 4'd2};
    good_need = 4'd3;
    revertive = 1'b0;
    manual_en = 1'b0;
    manual_sel = '0;
    los_clr = '0;
    t_reset();
    t_qualify();
    t_boundary();
    t_recovery();
    t_failover();
    t_revert();
    t_holdover();
    t_manual();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule